// File: doc/BRIEF.md
# Interrupt Recognition and Gating Unit

This unit sits beside the sequencer of a simple in-order core. It watches the asynchronous event pins, and each cycle it shows which events are currently eligible. When the core signals an instruction boundary, it picks one of them. Edge-type requests (non-maskable, init, system-management) are captured in pending latches. The maskable request is a plain level. A bus-check seen with a data-ready strobe is kept in a sticky flag until it can be reported.

Each source has its own gating rule. Non-maskable and init requests stay parked while the core is in system-management mode. They are released for the boundary after an interrupt-return, or once a resume-from-SMM pulse has been seen. A system-management request waits while the debug-ready line is high. A bus-check that arrives inside a locked sequence or an inquire cycle is withheld until that sequence ends or the inquire writeback finishes. When several events are eligible at one boundary, a fixed priority chooses the winner. The take strobe clears only the winner's latch.

Top module: `evt_gate`

## Requirements
- R1: A rising edge on `nmi_in`, `init_in` or `smi_in` sets that source's pending latch. The latch is visible in `pend_vec` from the following cycle. An input that stays high does not set the latch again after it has been taken.
- R2: `pend_vec[4]` (maskable request) equals `intr_in & if_flag` in the same cycle. Nothing is latched, so dropping `intr_in` removes the request.
- R3: While `in_smm` is high, latched NMI (`pend_vec[3]`) and INIT (`pend_vec[1]`) are hidden. An `iret_pulse` during SMM shows them from the next cycle up to and including the next `boundary` cycle.
- R4: After `rsm_pulse`, latched NMI and INIT are shown from the next cycle, even if `in_smm` is still high, until `in_smm` goes low.
- R5: A latched SMI (`pend_vec[2]`) is hidden while `prdy` is high and is shown once `prdy` is low. The latch is kept throughout.
- R6: `buschk_in` is sampled only in cycles with `brdy` high. A sample sets a sticky machine-check flag that survives the input dropping.
- R7: A bus-check sampled while `locked` is high, without `lock_last_brdy` in the same cycle, is withheld until the cycle after `lock_last_brdy`.
- R8: A bus-check sampled while `inquire` is high, without `inq_wb_done` in the same cycle, is withheld until the cycle after `inq_wb_done`.
- R9: `pend_vec[0]` (machine check) is shown only while `mce_enable` is high. The flag itself is kept while disabled.
- R10: `take` equals `boundary & |pend_vec`. When `take` is high, `grant_vec` is one-hot on the lowest set index of `pend_vec`; otherwise it is zero. Bit order is 0 machine check, 1 INIT, 2 SMI, 3 NMI, 4 INTR.
- R11: A take clears only the granted source's latch, from the next cycle on. All other latches are unchanged.
- R12: Synchronous `rst` clears every pending latch, the bus-check hold flags and the SMM return tracking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| nmi_in | input | 1 | Non-maskable request, edge |
| init_in | input | 1 | Init request, edge |
| intr_in | input | 1 | Maskable request, level |
| smi_in | input | 1 | System-management request, edge |
| buschk_in | input | 1 | Bus-check, sampled with `brdy` |
| if_flag | input | 1 | Maskable-interrupt enable flag |
| in_smm | input | 1 | Core is in system-management mode |
| iret_pulse | input | 1 | Interrupt-return retired |
| rsm_pulse | input | 1 | Resume-from-SMM retired |
| prdy | input | 1 | Debug-ready; defers SMI |
| brdy | input | 1 | Bus data-ready strobe |
| locked | input | 1 | Locked bus sequence in progress |
| lock_last_brdy | input | 1 | Final data-ready of locked sequence |
| inquire | input | 1 | Inquire cycle in progress |
| inq_wb_done | input | 1 | Inquire-caused writeback finished |
| mce_enable | input | 1 | Machine-check report enable |
| boundary | input | 1 | Instruction boundary this cycle |
| pend_vec | output | 5 | Eligible events |
| grant_vec | output | 5 | One-hot event taken this cycle |
| take | output | 1 | Event taken at this boundary |

## Verification
On every cycle the assertions check the shape of the grant: it is one-hot and occurs only at a boundary. They also check that the maskable, debug-ready and enable gates never leak a request, that a bus-check sampled in a locked or inquire cycle is withheld on the next cycle, and that a taken NMI is gone afterwards. The bench scenarios cover the behaviours that span many cycles: interrupt-return arming for exactly one boundary, release on resume from SMM, deferred SMI surviving a long debug-ready window, and the priority order across a burst of takes.

// File: rtl/evt_gate_pkg.sv
package evt_gate_pkg;
    localparam int EVT_N   = 5;
    localparam int EV_MCHK = 0;
    localparam int EV_INIT = 1;
    localparam int EV_SMI  = 2;
    localparam int EV_NMI  = 3;
    localparam int EV_INTR = 4;

    // edge-latched sources, index order inside the latch bank
    localparam int EDGE_N    = 3;
    localparam int EDGE_INIT = 0;
    localparam int EDGE_SMI  = 1;
    localparam int EDGE_NMI  = 2;

    typedef struct packed {
        logic prev;
        logic pend;
    } edge_st_t;

    typedef struct packed {
        logic seen;
        logic hold_lock;
        logic hold_inq;
    } mchk_st_t;

    typedef struct packed {
        logic armed;
        logic exit_pend;
    } smm_st_t;
endpackage

// File: rtl/evt_edge_latch.sv
module evt_edge_latch
    import evt_gate_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic clr,
    output logic pend
);
    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = din;
        if (clr)
            st_d.pend = 1'b0;
        if (din && !st_q.prev)
            st_d.pend = 1'b1;   // a fresh edge wins over a same-cycle clear
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign pend = st_q.pend;
endmodule

// File: rtl/evt_mchk_hold.sv
module evt_mchk_hold
    import evt_gate_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic buschk,
    input  logic brdy,
    input  logic locked,
    input  logic lock_last,
    input  logic inquire,
    input  logic inq_done,
    input  logic clr,
    output logic ready
);
    mchk_st_t st_d, st_q;
    logic     sample;

    assign sample = brdy & buschk;

    always_comb begin
        st_d = st_q;
        if (clr)
            st_d.seen = 1'b0;
        if (sample)
            st_d.seen = 1'b1;

        if (lock_last)
            st_d.hold_lock = 1'b0;
        else if (sample && locked)
            st_d.hold_lock = 1'b1;

        if (inq_done)
            st_d.hold_inq = 1'b0;
        else if (sample && inquire)
            st_d.hold_inq = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign ready = st_q.seen & ~st_q.hold_lock & ~st_q.hold_inq;
endmodule

// File: rtl/evt_prio_pick.sv
module evt_prio_pick #(
    parameter int N = 5
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    logic [N-1:0] higher;

    for (genvar i = 0; i < N; i++) begin : g_pick
        if (i == 0) begin : g_top
            assign higher[i] = 1'b0;
        end else begin : g_rest
            assign higher[i] = higher[i-1] | req[i-1];
        end
        assign grant[i] = req[i] & ~higher[i];
    end
endmodule

// File: rtl/evt_gate.sv
module evt_gate
    import evt_gate_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             nmi_in,
    input  logic             init_in,
    input  logic             intr_in,
    input  logic             smi_in,
    input  logic             buschk_in,
    input  logic             if_flag,
    input  logic             in_smm,
    input  logic             iret_pulse,
    input  logic             rsm_pulse,
    input  logic             prdy,
    input  logic             brdy,
    input  logic             locked,
    input  logic             lock_last_brdy,
    input  logic             inquire,
    input  logic             inq_wb_done,
    input  logic             mce_enable,
    input  logic             boundary,
    output logic [EVT_N-1:0] pend_vec,
    output logic             take,
    output logic [EVT_N-1:0] grant_vec
);
    logic [EDGE_N-1:0] edge_din;
    logic [EDGE_N-1:0] edge_clr;
    logic [EDGE_N-1:0] edge_pend;
    logic [EVT_N-1:0]  pick;
    logic              mc_ready;
    logic              smm_open;
    smm_st_t           smm_d, smm_q;

    assign edge_din[EDGE_INIT] = init_in;
    assign edge_din[EDGE_SMI]  = smi_in;
    assign edge_din[EDGE_NMI]  = nmi_in;
    assign edge_clr[EDGE_INIT] = grant_vec[EV_INIT];
    assign edge_clr[EDGE_SMI]  = grant_vec[EV_SMI];
    assign edge_clr[EDGE_NMI]  = grant_vec[EV_NMI];

    for (genvar k = 0; k < EDGE_N; k++) begin : g_edge
        evt_edge_latch u_latch (
            .clk  (clk),
            .rst  (rst),
            .din  (edge_din[k]),
            .clr  (edge_clr[k]),
            .pend (edge_pend[k])
        );
    end

    evt_mchk_hold u_mchk (
        .clk       (clk),
        .rst       (rst),
        .buschk    (buschk_in),
        .brdy      (brdy),
        .locked    (locked),
        .lock_last (lock_last_brdy),
        .inquire   (inquire),
        .inq_done  (inq_wb_done),
        .clr       (grant_vec[EV_MCHK]),
        .ready     (mc_ready)
    );

    // SMM return tracking: IRET opens one boundary, RSM opens until SMM drops
    always_comb begin
        smm_d = smm_q;
        if (!in_smm) begin
            smm_d.armed     = 1'b0;
            smm_d.exit_pend = 1'b0;
        end else begin
            if (iret_pulse)
                smm_d.armed = 1'b1;
            else if (boundary)
                smm_d.armed = 1'b0;
            if (rsm_pulse)
                smm_d.exit_pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            smm_q <= '0;
        else
            smm_q <= smm_d;
    end

    assign smm_open = ~in_smm | smm_q.armed | smm_q.exit_pend;

    always_comb begin
        pend_vec          = '0;
        pend_vec[EV_MCHK] = mc_ready & mce_enable;
        pend_vec[EV_INIT] = edge_pend[EDGE_INIT] & smm_open;
        pend_vec[EV_SMI]  = edge_pend[EDGE_SMI] & ~prdy;
        pend_vec[EV_NMI]  = edge_pend[EDGE_NMI] & smm_open;
        pend_vec[EV_INTR] = intr_in & if_flag;
    end

    evt_prio_pick #(.N(EVT_N)) u_pick (
        .req   (pend_vec),
        .grant (pick)
    );

    assign take      = boundary & (|pend_vec);
    assign grant_vec = take ? pick : '0;
endmodule

// File: rtl/evt_gate_chk.sv
module evt_gate_chk
    import evt_gate_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             nmi_in,
    input logic             intr_in,
    input logic             buschk_in,
    input logic             if_flag,
    input logic             prdy,
    input logic             brdy,
    input logic             locked,
    input logic             lock_last_brdy,
    input logic             inquire,
    input logic             inq_wb_done,
    input logic             mce_enable,
    input logic             boundary,
    input logic [EVT_N-1:0] pend_vec,
    input logic             take,
    input logic [EVT_N-1:0] grant_vec
);
    a_r10_grant_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_vec));

    a_r10_take_at_boundary: assert property (@(posedge clk) disable iff (rst)
        take |-> boundary && (grant_vec != '0));

    a_r2_intr_gated: assert property (@(posedge clk) disable iff (rst)
        pend_vec[EV_INTR] |-> (intr_in && if_flag));

    a_r5_smi_deferred: assert property (@(posedge clk) disable iff (rst)
        prdy |-> !pend_vec[EV_SMI]);

    a_r9_mce_gate: assert property (@(posedge clk) disable iff (rst)
        !mce_enable |-> !pend_vec[EV_MCHK]);

    a_r7_lock_hold: assert property (@(posedge clk) disable iff (rst)
        (brdy && buschk_in && locked && !lock_last_brdy) |=> !pend_vec[EV_MCHK]);

    a_r8_inquire_hold: assert property (@(posedge clk) disable iff (rst)
        (brdy && buschk_in && inquire && !inq_wb_done) |=> !pend_vec[EV_MCHK]);

    a_r11_nmi_cleared: assert property (@(posedge clk) disable iff (rst)
        (take && grant_vec[EV_NMI] && !nmi_in) |=> !pend_vec[EV_NMI]);

    a_r12_reset_clears: assert property (@(posedge clk)
        rst |=> (pend_vec[EV_NMI:EV_MCHK] == '0));
endmodule

bind evt_gate evt_gate_chk u_chk (.*);

// File: tb/evt_gate_test.sv
`timescale 1ns/1ps
module evt_gate_test;
    logic clk = 1'b0;
    logic rst;
    logic nmi_in, init_in, intr_in, smi_in, buschk_in, if_flag, in_smm;
    logic iret_pulse, rsm_pulse, prdy, brdy, locked, lock_last_brdy;
    logic inquire, inq_wb_done, mce_enable, boundary;
    logic [4:0] pend_vec, grant_vec;
    logic take;

    int total = 0;
    int bad   = 0;

    // model state (current and next)
    logic m_np, m_ip, m_sp, m_n, m_i, m_s, m_mc, m_hl, m_hi, m_arm, m_ex;
    logic n_np, n_ip, n_sp, n_n, n_i, n_s, n_mc, n_hl, n_hi, n_arm, n_ex;

    always #4 clk = ~clk;

    evt_gate uut (
        .clk(clk), .rst(rst), .nmi_in(nmi_in), .init_in(init_in),
        .intr_in(intr_in), .smi_in(smi_in), .buschk_in(buschk_in),
        .if_flag(if_flag), .in_smm(in_smm), .iret_pulse(iret_pulse),
        .rsm_pulse(rsm_pulse), .prdy(prdy), .brdy(brdy), .locked(locked),
        .lock_last_brdy(lock_last_brdy), .inquire(inquire),
        .inq_wb_done(inq_wb_done), .mce_enable(mce_enable),
        .boundary(boundary), .pend_vec(pend_vec), .take(take),
        .grant_vec(grant_vec)
    );

    function automatic logic [4:0] exp_pend();
        logic open;
        logic [4:0] p;
        open = !in_smm || m_arm || m_ex;
        p[0] = m_mc && !m_hl && !m_hi && mce_enable;
        p[1] = m_i && open;
        p[2] = m_s && !prdy;
        p[3] = m_n && open;
        p[4] = intr_in && if_flag;
        return p;
    endfunction

    function automatic logic [4:0] exp_grant(input logic [4:0] p, input logic b);
        logic [4:0] g = '0;
        if (b) begin
            for (int i = 4; i >= 0; i--)
                if (p[i]) g = 5'b00001 << i;
        end
        return g;
    endfunction

    task automatic zero_in();
        nmi_in = 0; init_in = 0; intr_in = 0; smi_in = 0; buschk_in = 0;
        if_flag = 0; in_smm = 0; iret_pulse = 0; rsm_pulse = 0; prdy = 0;
        brdy = 0; locked = 0; lock_last_brdy = 0; inquire = 0;
        inq_wb_done = 0; mce_enable = 1; boundary = 0;
    endtask

    task automatic cyc_begin();
        @(negedge clk);
        m_np = n_np; m_ip = n_ip; m_sp = n_sp; m_n = n_n; m_i = n_i;
        m_s = n_s; m_mc = n_mc; m_hl = n_hl; m_hi = n_hi; m_arm = n_arm;
        m_ex = n_ex;
        iret_pulse = 0; rsm_pulse = 0; lock_last_brdy = 0;
        inq_wb_done = 0; boundary = 0;
    endtask

    task automatic cyc_end(input string tag);
        logic [4:0] ep, eg;
        logic et, samp;
        #1;
        ep = exp_pend();
        et = boundary && (ep != 0);
        eg = exp_grant(ep, boundary);
        if (!rst) begin
            total++;
            if (pend_vec !== ep || grant_vec !== eg || take !== et) begin
                bad++;
                $display("FAIL %s: actual pend=%b grant=%b take=%b expected pend=%b grant=%b take=%b",
                         tag, pend_vec, grant_vec, take, ep, eg, et);
            end
        end
        if (rst) begin
            {n_np, n_ip, n_sp, n_n, n_i, n_s, n_mc, n_hl, n_hi, n_arm, n_ex} = '0;
        end else begin
            n_np = nmi_in; n_ip = init_in; n_sp = smi_in;
            n_n = (nmi_in && !m_np) ? 1'b1 : (eg[3] ? 1'b0 : m_n);
            n_i = (init_in && !m_ip) ? 1'b1 : (eg[1] ? 1'b0 : m_i);
            n_s = (smi_in && !m_sp) ? 1'b1 : (eg[2] ? 1'b0 : m_s);
            samp = brdy && buschk_in;
            n_mc = samp ? 1'b1 : (eg[0] ? 1'b0 : m_mc);
            n_hl = lock_last_brdy ? 1'b0 : ((samp && locked) ? 1'b1 : m_hl);
            n_hi = inq_wb_done ? 1'b0 : ((samp && inquire) ? 1'b1 : m_hi);
            n_arm = !in_smm ? 1'b0 : (iret_pulse ? 1'b1 : (boundary ? 1'b0 : m_arm));
            n_ex  = !in_smm ? 1'b0 : (rsm_pulse ? 1'b1 : m_ex);
        end
    endtask

    task automatic idle(input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            cyc_begin();
            cyc_end(tag);
        end
    endtask

    task automatic do_reset();
        cyc_begin(); rst = 1; cyc_end("R12 reset");
        cyc_begin(); rst = 1; cyc_end("R12 reset");
        cyc_begin(); rst = 0; cyc_end("R12 state after reset");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL R10 watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4421));
        {n_np, n_ip, n_sp, n_n, n_i, n_s, n_mc, n_hl, n_hi, n_arm, n_ex} = '0;
        rst = 1;
        zero_in();
        do_reset();

        // R1: edge latch, visible next cycle, held input does not relatch
        cyc_begin(); nmi_in = 1; cyc_end("R1 edge cycle");
        idle(2, "R1 nmi pending");
        cyc_begin(); boundary = 1; cyc_end("R1 take nmi");
        idle(3, "R1 held high no relatch");
        cyc_begin(); nmi_in = 0; init_in = 1; cyc_end("R1 init edge");
        cyc_begin(); boundary = 1; cyc_end("R1 take init");
        cyc_begin(); init_in = 0; cyc_end("R1 init low");

        // R2: level request, no latch
        cyc_begin(); intr_in = 1; cyc_end("R2 masked");
        cyc_begin(); if_flag = 1; cyc_end("R2 enabled");
        cyc_begin(); intr_in = 0; cyc_end("R2 dropped lost");
        cyc_begin(); if_flag = 0; cyc_end("R2 idle");

        // R3: SMM hides NMI, IRET opens one boundary
        cyc_begin(); in_smm = 1; nmi_in = 1; cyc_end("R3 nmi in smm");
        idle(2, "R3 hidden in smm");
        cyc_begin(); boundary = 1; cyc_end("R3 no take in smm");
        cyc_begin(); iret_pulse = 1; cyc_end("R3 iret pulse");
        idle(2, "R3 armed after iret");
        cyc_begin(); intr_in = 1; boundary = 1; cyc_end("R3 boundary after iret");
        cyc_begin(); intr_in = 0; nmi_in = 0; cyc_end("R3 closed again");
        cyc_begin(); nmi_in = 1; cyc_end("R3 second nmi");
        cyc_begin(); iret_pulse = 1; boundary = 1; cyc_end("R3 iret with boundary");
        cyc_begin(); cyc_end("R3 armed");
        cyc_begin(); boundary = 1; cyc_end("R3 take after iret");

        // R4: RSM releases latched events while in_smm still high
        cyc_begin(); nmi_in = 0; init_in = 1; cyc_end("R4 init in smm");
        idle(2, "R4 hidden");
        cyc_begin(); rsm_pulse = 1; cyc_end("R4 rsm");
        idle(2, "R4 released");
        cyc_begin(); in_smm = 0; cyc_end("R4 smm left");
        cyc_begin(); boundary = 1; cyc_end("R4 take init");
        cyc_begin(); init_in = 0; cyc_end("R4 done");

        // R5: SMI deferred by prdy
        cyc_begin(); prdy = 1; smi_in = 1; cyc_end("R5 smi latch");
        idle(5, "R5 deferred");
        cyc_begin(); boundary = 1; cyc_end("R5 no take");
        cyc_begin(); prdy = 0; cyc_end("R5 released");
        cyc_begin(); boundary = 1; cyc_end("R5 take smi");
        cyc_begin(); smi_in = 0; cyc_end("R5 done");

        // R6: sampled only with brdy, sticky
        cyc_begin(); buschk_in = 1; cyc_end("R6 no brdy");
        cyc_begin(); buschk_in = 0; cyc_end("R6 nothing latched");
        cyc_begin(); buschk_in = 1; brdy = 1; cyc_end("R6 sampled");
        cyc_begin(); buschk_in = 0; brdy = 0; cyc_end("R6 sticky");
        idle(2, "R6 sticky");
        // R9: enable gate keeps the flag
        cyc_begin(); mce_enable = 0; cyc_end("R9 disabled");
        cyc_begin(); boundary = 1; cyc_end("R9 no take disabled");
        cyc_begin(); mce_enable = 1; cyc_end("R9 enabled");
        cyc_begin(); boundary = 1; cyc_end("R9 take mchk");

        // R7: locked hold
        cyc_begin(); locked = 1; brdy = 1; buschk_in = 1; cyc_end("R7 sample locked");
        cyc_begin(); brdy = 0; buschk_in = 0; cyc_end("R7 held");
        idle(3, "R7 held");
        cyc_begin(); lock_last_brdy = 1; brdy = 1; cyc_end("R7 last brdy");
        cyc_begin(); brdy = 0; locked = 0; cyc_end("R7 released");
        cyc_begin(); boundary = 1; cyc_end("R7 take");

        // R8: inquire hold
        cyc_begin(); inquire = 1; brdy = 1; buschk_in = 1; cyc_end("R8 sample inquire");
        cyc_begin(); brdy = 0; buschk_in = 0; inquire = 0; cyc_end("R8 held");
        idle(3, "R8 held");
        cyc_begin(); inq_wb_done = 1; cyc_end("R8 wb done");
        cyc_begin(); cyc_end("R8 released");
        cyc_begin(); boundary = 1; cyc_end("R8 take");

        // R10, R11: all pending, taken in priority order, others untouched
        cyc_begin(); nmi_in = 1; init_in = 1; smi_in = 1; brdy = 1; buschk_in = 1;
        intr_in = 1; if_flag = 1; cyc_end("R10 raise all");
        cyc_begin(); nmi_in = 0; init_in = 0; smi_in = 0; brdy = 0; buschk_in = 0;
        cyc_end("R10 all pending");
        for (int k = 0; k < 5; k++) begin
            cyc_begin(); boundary = 1; cyc_end("R10 R11 priority take");
            cyc_begin(); cyc_end("R11 others kept");
        end
        cyc_begin(); intr_in = 0; if_flag = 0; cyc_end("R11 done");

        // R12: reset with state pending
        cyc_begin(); nmi_in = 1; smi_in = 1; brdy = 1; buschk_in = 1; cyc_end("R12 load");
        cyc_begin(); nmi_in = 0; smi_in = 0; brdy = 0; buschk_in = 0; cyc_end("R12 loaded");
        do_reset();
        idle(2, "R12 cleared");

        // random mix
        for (int k = 0; k < 3000; k++) begin
            cyc_begin();
            if ($urandom % 8 == 0) nmi_in = ~nmi_in;
            if ($urandom % 10 == 0) init_in = ~init_in;
            if ($urandom % 9 == 0) smi_in = ~smi_in;
            if ($urandom % 20 == 0) in_smm = ~in_smm;
            if ($urandom % 6 == 0) prdy = ~prdy;
            if ($urandom % 10 == 0) locked = ~locked;
            if ($urandom % 10 == 0) inquire = ~inquire;
            intr_in        = ($urandom % 4 == 0);
            if_flag        = ($urandom % 2 == 0);
            brdy           = ($urandom % 2 == 0);
            buschk_in      = ($urandom % 8 == 0);
            iret_pulse     = ($urandom % 16 == 0);
            rsm_pulse      = ($urandom % 16 == 0);
            lock_last_brdy = ($urandom % 8 == 0);
            inq_wb_done    = ($urandom % 8 == 0);
            mce_enable     = ($urandom % 8 != 0);
            boundary       = ($urandom % 3 == 0);
            cyc_end("R10 random mix");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule